// File: doc/BRIEF.md
# Page Symbol Correction Applier

This block takes a short list of symbol corrections for one flash page and folds them into a byte-wide page buffer that holds the main data bytes followed by the spare bytes. Each correction carries a 12-bit error pattern and the index of the 12-bit symbol it belongs to. Because 12-bit symbols are packed two to every three bytes, a symbol covers either a whole byte and a nibble, or a nibble and a whole byte. The block works out which bytes are touched and applies the pattern to each one with a read-modify-write cycle on the buffer port.

Corrections arrive on a valid/ready stream with a last marker that closes the list for a page. Entries that point outside the correctable area, carry bits that have no byte to land in, or exceed the per-page budget are rejected without touching the buffer. When the last entry of a list has been handled, the block pulses a status carrying the number of symbols applied and a flag that marks the page uncorrectable.

Top module: `sym_fix_applier`

## Requirements
- R1: After reset, in_ready is 1, buf_rd and buf_we are 0 and status_valid is 0.
- R2: For an odd symbol index p and pattern e, with b = floor(3p/2), byte b is XORed with e[11:4] and byte b+1 is XORed with {e[3:0], 4'b0000}.
- R3: For an even symbol index p > 0 and pattern e, with b = 3p/2, byte b-1 is XORed with {4'b0000, e[11:8]} and byte b is XORed with e[7:0].
- R4: Index 0 touches byte 0 only (XOR with e[7:0]); if e[11:8] is nonzero at index 0 the entry is rejected.
- R5: Index 1365 spans the boundary: main byte 2047 takes e[11:4] and spare byte 0 takes e[3:0] in its upper nibble.
- R6: The buffer address space is linear: main bytes sit at 0..2047 and spare byte k at 2048+k, so indices above 1365 land in the spare area with the 2048 offset.
- R7: Any index above 1374 is rejected.
- R8: At most four entries per list are applied; further entries in the same list are rejected.
- R9: Every touched byte costs one read cycle followed by one write of read data XOR mask to the same address on the next cycle; a rejected entry makes no buffer access.
- R10: in_ready is high only while the block is idle; it is low in the cycle after an entry is accepted.
- R11: After the entry marked last has been handled, status_valid is high for exactly one cycle with status_count equal to the entries applied in that list and status_fail set if any entry of the list was rejected; the next list starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Correction entry valid |
| in_ready | output | 1 | Block can accept an entry |
| in_pos | input | 11 | Symbol index of the entry |
| in_pattern | input | 12 | Error pattern of the entry |
| in_last | input | 1 | Entry closes the list for this page |
| buf_addr | output | 12 | Page buffer byte address |
| buf_rd | output | 1 | Buffer read strobe, data one cycle later |
| buf_rdata | input | 8 | Buffer read data |
| buf_we | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Buffer write data |
| status_valid | output | 1 | One-cycle list result strobe |
| status_count | output | 3 | Symbols applied in the list |
| status_fail | output | 1 | Page uncorrectable |

## Verification
The bench builds the block with its default sizes: 2048 main bytes, 64 spare bytes, a highest index of 1374 and a budget of four, so the buffer model covers the full 2112-byte page. With those values the boundary-straddling index 1365, the first spare indices, the last legal index 1374 and its neighbour 1375 are all directly reachable, as is the fifth-entry overflow of the budget. The bench keeps a byte-accurate copy of the expected page and counts buffer reads and writes per list.

// File: rtl/sfa_pkg.sv
package sfa_pkg;

    localparam int BYTE_W = 8;
    localparam int SYM_W  = 12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_LO,
        ST_WR_LO,
        ST_RD_HI,
        ST_WR_HI,
        ST_FINISH
    } eng_state_t;

    // Byte masks a single symbol contributes to the one or two bytes it covers.
    typedef struct packed {
        logic              lo_used;
        logic [BYTE_W-1:0] lo_mask;
        logic [BYTE_W-1:0] hi_mask;
    } sym_masks_t;

    // Split a 12-bit pattern into the masks for the lower and upper byte.
    // An odd symbol starts on a byte boundary; an even one ends on it.
    function automatic sym_masks_t split_pattern(input logic [SYM_W-1:0] pat,
                                                 input logic odd_pos,
                                                 input logic first_pos);
        sym_masks_t m;
        if (odd_pos) begin
            m.lo_mask = pat[11:4];
            m.hi_mask = {pat[3:0], 4'b0000};
            m.lo_used = 1'b1;
        end else begin
            m.lo_mask = {4'b0000, pat[11:8]};
            m.hi_mask = pat[7:0];
            m.lo_used = !first_pos;
        end
        return m;
    endfunction

endpackage

// File: rtl/sfa_decoder.sv
module sfa_decoder
    import sfa_pkg::*;
#(
    parameter int POS_W   = 11,
    parameter int ADDR_W  = 12,
    parameter int MAX_POS = 1374
) (
    input  logic [POS_W-1:0]  pos,
    input  logic [SYM_W-1:0]  pattern,
    output logic [ADDR_W-1:0] lo_addr,
    output logic [ADDR_W-1:0] hi_addr,
    output sym_masks_t        masks,
    output logic              bad_entry
);

    localparam int BASE_W = POS_W + 2;

    logic [BASE_W-1:0] triple;
    logic [BASE_W-1:0] base;
    logic              odd_pos;
    logic              first_pos;

    always_comb begin
        triple    = BASE_W'(pos) + BASE_W'({pos, 1'b0});
        base      = triple >> 1;
        odd_pos   = pos[0];
        first_pos = (pos == '0);
        masks     = split_pattern(pattern, odd_pos, first_pos);
        if (odd_pos) begin
            lo_addr = ADDR_W'(base);
            hi_addr = ADDR_W'(base + BASE_W'(1));
        end else begin
            lo_addr = ADDR_W'(base - BASE_W'(1));
            hi_addr = ADDR_W'(base);
        end
        // Past the check area, or index 0 with bits above the first byte.
        bad_entry = (32'(pos) > MAX_POS) || (first_pos && (pattern[11:8] != 4'h0));
    end

endmodule

// File: rtl/sfa_tally.sv
module sfa_tally #(
    parameter int MAX_CORR = 4,
    localparam int CNT_W   = $clog2(MAX_CORR + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             applied,
    input  logic             rejected,
    input  logic             clear,
    output logic [CNT_W-1:0] count,
    output logic             fail,
    output logic             full
);

    assign full = (32'(count) >= MAX_CORR);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
            fail  <= 1'b0;
        end else begin
            if (applied && !full) begin
                count <= count + CNT_W'(1);
            end
            if (rejected) begin
                fail <= 1'b1;
            end
        end
    end

    // R8: the applied count never exceeds the per-page budget
    p_count_budget_r8: assert property (@(posedge clk) disable iff (rst)
        32'(count) <= MAX_CORR);

    // R8: a full budget is never exceeded by a further apply
    p_no_apply_when_full_r8: assert property (@(posedge clk) disable iff (rst)
        (full && !clear) |=> (count == $past(count)) || (count == '0));

endmodule

// File: rtl/sfa_rmw_engine.sv
module sfa_rmw_engine
    import sfa_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int TOTAL_BYTES = 2112
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_last,
    input  logic [ADDR_W-1:0] dec_lo_addr,
    input  logic [ADDR_W-1:0] dec_hi_addr,
    input  sym_masks_t        dec_masks,
    input  logic              dec_reject,
    output logic              apply_pulse,
    output logic              reject_pulse,
    output logic              list_done,
    output logic [ADDR_W-1:0] buf_addr,
    output logic              buf_rd,
    input  logic [BYTE_W-1:0] buf_rdata,
    output logic              buf_we,
    output logic [BYTE_W-1:0] buf_wdata
);

    eng_state_t        state, state_nx;
    logic [ADDR_W-1:0] lo_addr_q, hi_addr_q;
    sym_masks_t        masks_q;
    logic              last_q;
    logic              accept;

    assign in_ready     = (state == ST_IDLE);
    assign accept       = in_valid && in_ready;
    assign apply_pulse  = accept && !dec_reject;
    assign reject_pulse = accept && dec_reject;
    assign list_done    = (state == ST_FINISH) && last_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (dec_reject)             state_nx = ST_FINISH;
                    else if (dec_masks.lo_used) state_nx = ST_RD_LO;
                    else                        state_nx = ST_RD_HI;
                end
            end
            ST_RD_LO:  state_nx = ST_WR_LO;
            ST_WR_LO:  state_nx = ST_RD_HI;
            ST_RD_HI:  state_nx = ST_WR_HI;
            ST_WR_HI:  state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            lo_addr_q <= '0;
            hi_addr_q <= '0;
            masks_q   <= '0;
            last_q    <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                lo_addr_q <= dec_lo_addr;
                hi_addr_q <= dec_hi_addr;
                masks_q   <= dec_masks;
                last_q    <= in_last;
            end
        end
    end

    always_comb begin
        buf_rd    = 1'b0;
        buf_we    = 1'b0;
        buf_addr  = '0;
        buf_wdata = '0;
        unique case (state)
            ST_RD_LO: begin
                buf_rd   = 1'b1;
                buf_addr = lo_addr_q;
            end
            ST_WR_LO: begin
                buf_we    = 1'b1;
                buf_addr  = lo_addr_q;
                buf_wdata = buf_rdata ^ masks_q.lo_mask;
            end
            ST_RD_HI: begin
                buf_rd   = 1'b1;
                buf_addr = hi_addr_q;
            end
            ST_WR_HI: begin
                buf_we    = 1'b1;
                buf_addr  = hi_addr_q;
                buf_wdata = buf_rdata ^ masks_q.hi_mask;
            end
            default: ;
        endcase
    end

    // R9: each write lands one cycle after a read of the same byte
    p_write_follows_read_r9: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> ($past(buf_rd) && (buf_addr == $past(buf_addr))));

    // R9: a read is always followed by its write
    p_read_then_write_r9: assert property (@(posedge clk) disable iff (rst)
        buf_rd |=> buf_we);

    // R6: accesses stay inside the page buffer
    p_addr_in_page_r6: assert property (@(posedge clk) disable iff (rst)
        (buf_rd || buf_we) |-> (32'(buf_addr) < TOTAL_BYTES));

    // R10: ready drops after an entry is taken
    p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (rst)
        accept |=> !in_ready);

    // R10: no buffer access while ready is offered
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> !(buf_rd || buf_we));

    // R11: the list result is a single-cycle strobe
    p_status_strobe_r11: assert property (@(posedge clk) disable iff (rst)
        list_done |=> !list_done);

endmodule

// File: rtl/sym_fix_applier.sv
module sym_fix_applier
    import sfa_pkg::*;
#(
    parameter int DATA_BYTES  = 2048,
    parameter int SPARE_BYTES = 64,
    parameter int MAX_POS     = 1374,
    parameter int MAX_CORR    = 4,
    parameter int POS_W       = 11,
    localparam int TOTAL_BYTES = DATA_BYTES + SPARE_BYTES,
    localparam int ADDR_W      = $clog2(TOTAL_BYTES),
    localparam int CNT_W       = $clog2(MAX_CORR + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [POS_W-1:0]  in_pos,
    input  logic [SYM_W-1:0]  in_pattern,
    input  logic              in_last,
    output logic [ADDR_W-1:0] buf_addr,
    output logic              buf_rd,
    input  logic [BYTE_W-1:0] buf_rdata,
    output logic              buf_we,
    output logic [BYTE_W-1:0] buf_wdata,
    output logic              status_valid,
    output logic [CNT_W-1:0]  status_count,
    output logic              status_fail
);

    logic [ADDR_W-1:0] dec_lo_addr, dec_hi_addr;
    sym_masks_t        dec_masks;
    logic              dec_bad;
    logic              budget_full;
    logic              apply_pulse, reject_pulse, list_done;
    logic [CNT_W-1:0]  tally_count;
    logic              tally_fail;

    sfa_decoder #(
        .POS_W  (POS_W),
        .ADDR_W (ADDR_W),
        .MAX_POS(MAX_POS)
    ) decoder_i (
        .pos      (in_pos),
        .pattern  (in_pattern),
        .lo_addr  (dec_lo_addr),
        .hi_addr  (dec_hi_addr),
        .masks    (dec_masks),
        .bad_entry(dec_bad)
    );

    sfa_rmw_engine #(
        .ADDR_W     (ADDR_W),
        .TOTAL_BYTES(TOTAL_BYTES)
    ) engine_i (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_last     (in_last),
        .dec_lo_addr (dec_lo_addr),
        .dec_hi_addr (dec_hi_addr),
        .dec_masks   (dec_masks),
        .dec_reject  (dec_bad || budget_full),
        .apply_pulse (apply_pulse),
        .reject_pulse(reject_pulse),
        .list_done   (list_done),
        .buf_addr    (buf_addr),
        .buf_rd      (buf_rd),
        .buf_rdata   (buf_rdata),
        .buf_we      (buf_we),
        .buf_wdata   (buf_wdata)
    );

    sfa_tally #(
        .MAX_CORR(MAX_CORR)
    ) tally_i (
        .clk     (clk),
        .rst     (rst),
        .applied (apply_pulse),
        .rejected(reject_pulse),
        .clear   (list_done),
        .count   (tally_count),
        .fail    (tally_fail),
        .full    (budget_full)
    );

    assign status_valid = list_done;
    assign status_count = tally_count;
    assign status_fail  = tally_fail;

    // R7 R4: an entry flagged out of range never reaches the buffer port
    p_reject_no_access_r7: assert property (@(posedge clk) disable iff (rst)
        reject_pulse |=> !(buf_rd || buf_we));

    // R11: a reported count never exceeds the budget
    p_status_count_r11: assert property (@(posedge clk) disable iff (rst)
        status_valid |-> (32'(status_count) <= MAX_CORR));

endmodule

// File: tb/sym_fix_applier_tb_top.sv
module sym_fix_applier_tb_top;

    localparam int DATA_BYTES  = 2048;
    localparam int SPARE_BYTES = 64;
    localparam int TOTAL       = DATA_BYTES + SPARE_BYTES;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [10:0] in_pos = '0;
    logic [11:0] in_pattern = '0;
    logic        in_last = 1'b0;
    logic [11:0] buf_addr;
    logic        buf_rd;
    logic [7:0]  buf_rdata = '0;
    logic        buf_we;
    logic [7:0]  buf_wdata;
    logic        status_valid;
    logic [2:0]  status_count;
    logic        status_fail;

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;

    logic [7:0] mem [TOTAL];
    logic [7:0] exp_mem [TOTAL];

    always #2.5 clk = ~clk;

    sym_fix_applier dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_pos(in_pos), .in_pattern(in_pattern), .in_last(in_last),
        .buf_addr(buf_addr), .buf_rd(buf_rd), .buf_rdata(buf_rdata),
        .buf_we(buf_we), .buf_wdata(buf_wdata),
        .status_valid(status_valid), .status_count(status_count),
        .status_fail(status_fail)
    );

    always @(posedge clk) begin
        if (buf_rd) begin
            buf_rdata <= mem[buf_addr];
            rd_cnt    <= rd_cnt + 1;
        end
        if (buf_we) begin
            mem[buf_addr] <= buf_wdata;
            wr_cnt        <= wr_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fill_page();
        for (int i = 0; i < TOTAL; i++) begin
            mem[i]     = 8'(i * 7 + 3);
            exp_mem[i] = 8'(i * 7 + 3);
        end
    endtask

    task automatic check_page(input string req);
        int bad_at = -1;
        for (int i = 0; i < TOTAL; i++) begin
            if (bad_at < 0 && mem[i] !== exp_mem[i]) bad_at = i;
        end
        if (bad_at < 0) check(1'b1, req, 0, 0);
        else check(1'b0, {req, " byte"}, int'(mem[bad_at]), int'(exp_mem[bad_at]));
    endtask

    // Expected effect of one accepted entry, from R2..R6.
    task automatic model_apply(input int p, input logic [11:0] e);
        int b = (3 * p) / 2;
        if (p % 2 == 1) begin
            exp_mem[b]     ^= e[11:4];
            exp_mem[b + 1] ^= {e[3:0], 4'b0000};
        end else if (p == 0) begin
            exp_mem[0] ^= e[7:0];
        end else begin
            exp_mem[b - 1] ^= {4'b0000, e[11:8]};
            exp_mem[b]     ^= e[7:0];
        end
    endtask

    task automatic send(input int p, input logic [11:0] e, input bit last, input string req);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid   = 1'b1;
        in_pos     = 11'(p);
        in_pattern = e;
        in_last    = last;
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        check(!in_ready, req, int'(in_ready), 0);
    endtask

    task automatic wait_status(input int exp_cnt, input bit exp_fail, input string req);
        int n = 0;
        while (!status_valid && n < 50) begin
            @(negedge clk);
            n++;
        end
        check(status_valid, {req, " status_valid"}, int'(status_valid), 1);
        check(int'(status_count) == exp_cnt, {req, " count"}, int'(status_count), exp_cnt);
        check(status_fail == exp_fail, {req, " fail"}, int'(status_fail), int'(exp_fail));
        @(negedge clk);
        check(!status_valid, {req, " strobe width"}, int'(status_valid), 0);
    endtask

    task automatic reset_counts();
        @(negedge clk);
        rd_cnt = 0;
        wr_cnt = 0;
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(in_ready === 1'b1, "R1 ready", int'(in_ready), 1);
        check(buf_rd === 1'b0 && buf_we === 1'b0, "R1 buffer idle", int'({buf_rd, buf_we}), 0);
        check(status_valid === 1'b0, "R1 status", int'(status_valid), 0);
    endtask

    task automatic test_odd();
        fill_page(); reset_counts();
        send(3, 12'hA5C, 1'b1, "R10 busy odd");
        model_apply(3, 12'hA5C);
        wait_status(1, 1'b0, "R2");
        check_page("R2 odd mapping");
        check(rd_cnt == 2 && wr_cnt == 2, "R9 two byte cycles", rd_cnt * 16 + wr_cnt, 8'h22);
    endtask

    task automatic test_even();
        fill_page(); reset_counts();
        send(4, 12'h3C7, 1'b1, "R10 busy even");
        model_apply(4, 12'h3C7);
        wait_status(1, 1'b0, "R3");
        check_page("R3 even mapping");
    endtask

    task automatic test_zero();
        fill_page(); reset_counts();
        send(0, 12'h0B6, 1'b1, "R10 busy zero");
        model_apply(0, 12'h0B6);
        wait_status(1, 1'b0, "R4 zero ok");
        check_page("R4 zero only byte 0");
        check(rd_cnt == 1 && wr_cnt == 1, "R4 single byte", rd_cnt * 16 + wr_cnt, 8'h11);
        fill_page(); reset_counts();
        send(0, 12'h1B6, 1'b1, "R10 busy zero bad");
        wait_status(0, 1'b1, "R4 zero reject");
        check_page("R4 reject leaves page");
        check(rd_cnt == 0 && wr_cnt == 0, "R9 no access on reject", rd_cnt * 16 + wr_cnt, 0);
    endtask

    task automatic test_boundary();
        fill_page();
        send(1365, 12'h9E3, 1'b1, "R10 busy straddle");
        model_apply(1365, 12'h9E3);
        wait_status(1, 1'b0, "R5");
        check_page("R5 straddle");
        check(mem[2048] === exp_mem[2048] && mem[2048] !== 8'(2048 * 7 + 3),
              "R5 spare byte 0 touched", int'(mem[2048]), int'(exp_mem[2048]));
    endtask

    task automatic test_spare();
        fill_page();
        send(1366, 12'h5A1, 1'b0, "R10 busy spare");
        send(1374, 12'hFFF, 1'b0, "R10 busy last pos");
        send(1375, 12'h123, 1'b1, "R10 busy out of range");
        model_apply(1366, 12'h5A1);
        model_apply(1374, 12'hFFF);
        wait_status(2, 1'b1, "R7");
        check_page("R6 spare mapping R7 range");
    endtask

    task automatic test_budget();
        fill_page();
        send(11, 12'h101, 1'b0, "R10 b1");
        send(20, 12'h202, 1'b0, "R10 b2");
        send(33, 12'h303, 1'b0, "R10 b3");
        send(100, 12'h404, 1'b0, "R10 b4");
        send(201, 12'h505, 1'b1, "R10 b5");
        model_apply(11, 12'h101);
        model_apply(20, 12'h202);
        model_apply(33, 12'h303);
        model_apply(100, 12'h404);
        wait_status(4, 1'b1, "R8");
        check_page("R8 fifth entry dropped");
        // Next list starts clean (R11).
        send(7, 12'h0F0, 1'b1, "R10 after budget");
        model_apply(7, 12'h0F0);
        wait_status(1, 1'b0, "R11 restart");
        check_page("R11 restart page");
    endtask

    task automatic test_same_byte();
        fill_page();
        send(5, 12'hFFF, 1'b0, "R10 s1");
        send(6, 12'hFFF, 1'b0, "R10 s2");
        send(5, 12'h0F0, 1'b1, "R10 s3");
        model_apply(5, 12'hFFF);
        model_apply(6, 12'hFFF);
        model_apply(5, 12'h0F0);
        wait_status(3, 1'b0, "R11 three");
        check_page("R2 R3 shared byte");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        fill_page();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_odd();
        test_even();
        test_zero();
        test_boundary();
        test_spare();
        test_budget();
        test_same_byte();
        repeat (4) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule